// File: doc/BRIEF.md
# Cache-Line-Crossing Access Splitter

This block sits between a load/store issue point and a memory port that only accepts accesses contained within one cache line. It takes a request carrying a byte address, a byte count, a read/write flag and a little-endian store data word. When the request stays inside one line, it is passed on as a single memory request. When the bytes run past a line boundary, the block issues two memory requests one after the other. The first covers the bytes up to the boundary and the second covers the bytes from the boundary onward.

For stores, each memory request carries only its own slice of the store word, moved down to byte lane 0. For loads, the returned bytes of each half are placed into one result word at their position within the original access. A finish counter counts the responses. A single done pulse, with the merged load data, is raised once the counter equals the number of halves issued. Only one request is in flight at a time. Upstream sees the block as busy from acceptance until its done pulse.

Top module: `line_split_unit`

## Requirements
- R1: An access is split exactly when B = (addr + size − 1) rounded down to a multiple of LINE_BYTES is strictly greater than addr; the second memory request then uses address B. No memory request ever covers bytes of two lines.
- R2: For a split access the first memory request has address addr and size B − addr, and the second has size (addr + size) − B.
- R3: An access that is not split produces one memory request with the original address and size, and done follows its single response.
- R4: At most one memory request is outstanding: after a request handshake, memValid stays low until that request's response has arrived, and the second half is issued only after the first half's response.
- R5: Store slicing: byte j of memWdata (bits 8j+7..8j) on the first half is store byte j, and on the second half is store byte j + (B − addr); every byte lane at or above memSize is zero. memWrite follows the request's write flag.
- R6: Load merge: byte i of doneRdata for i < size is byte i of the first response when i < B − addr, and byte i − (B − addr) of the second response otherwise (the whole access comes from the single response when unsplit). Bytes at or above size are zero. For stores doneRdata is zero.
- R7: doneValid is high for exactly one cycle, in the cycle after the response that brings the finish count to the number of halves. It stays low after the first response of a split access.
- R8: While memValid is high and memReady is low, memValid, memAddr, memSize, memWrite and memWdata hold their values.
- R9: reqReady is high only when the block is idle, which is again the case in the cycle after doneValid. A reqValid presented while busy is ignored and does not change any field of the access in progress.
- R10: A rspValid arriving while no response is awaited is ignored: it produces no done and does not alter the next access's merged data.
- R11: After reset reqReady is 1, memValid is 0 and doneValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Upstream request valid |
| reqReady | output | 1 | Block idle, request accepted when reqValid is high |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | clog2(MAX_BYTES+1) | Byte count, 1..MAX_BYTES |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqWdata | input | 8*MAX_BYTES | Store bytes, byte 0 in bits 7..0 |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request |
| memAddr | output | ADDR_W | Address of the current half |
| memSize | output | clog2(MAX_BYTES+1) | Byte count of the current half |
| memWrite | output | 1 | Store flag of the current half |
| memWdata | output | 8*MAX_BYTES | Store slice of the current half, lane 0 aligned |
| rspValid | input | 1 | Memory response valid |
| rspRdata | input | 8*MAX_BYTES | Response bytes, lane 0 aligned |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 8*MAX_BYTES | Merged load result |

## Verification
Every result has a fixed latency, and each check samples on the falling edge of the cycle in which its result is due. The first memory request is visible in the cycle after the accepting edge. memValid is low in the cycle after each request handshake. Following a first-half response, the next cycle shows either the second request with doneValid low, or the done pulse. doneValid and the merged data appear in the cycle after the final response, and reqReady returns one cycle later. The checks sample at exactly those offsets, so a result that is late, early or repeated is reported.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // latch a new access
    logic load0;      // merge first (or only) response
    logic load1;      // merge second response
    logic selSecond;  // memory port shows the second half
  } lsplit_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ISSUE_A = 3'd1,
    ST_WAIT_A  = 3'd2,
    ST_ISSUE_B = 3'd3,
    ST_WAIT_B  = 3'd4,
    ST_DONE    = 3'd5
  } lsplit_state_t;

endpackage

// File: rtl/lsplit_datapath.sv
module lsplit_datapath
  import lsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  lsplit_strobe_t               strobe,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [$clog2(MAX_BYTES+1)-1:0] reqSize,
  input  logic                         reqWrite,
  input  logic [8*MAX_BYTES-1:0]       reqWdata,
  input  logic [8*MAX_BYTES-1:0]       rspRdata,
  output logic                         isSplit,
  output logic                         isWrite,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [$clog2(MAX_BYTES+1)-1:0] memSize,
  output logic [8*MAX_BYTES-1:0]       memWdata,
  output logic [8*MAX_BYTES-1:0]       doneRdata
);

  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int SZ_W   = $clog2(MAX_BYTES + 1);
  localparam int SH_W   = SZ_W + 3;
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  // split calculation on the incoming request
  logic [ADDR_W-1:0] lastAddr, bndAddr;
  logic              crosses;
  logic [SZ_W-1:0]   headSize, tailSize;

  always_comb begin
    lastAddr = reqAddr + ADDR_W'(reqSize) - ADDR_W'(1);
    bndAddr  = lastAddr & ~LINE_MASK;
    crosses  = bndAddr > reqAddr;
    headSize = SZ_W'(bndAddr - reqAddr);
    tailSize = reqSize - headSize;
  end

  logic [ADDR_W-1:0] addrQ, bndQ;
  logic [SZ_W-1:0]   sizeQ, headQ, tailQ;
  logic              splitQ, writeQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      bndQ   <= '0;
      sizeQ  <= '0;
      headQ  <= '0;
      tailQ  <= '0;
      splitQ <= 1'b0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (strobe.capture) begin
      addrQ  <= reqAddr;
      bndQ   <= bndAddr;
      sizeQ  <= reqSize;
      headQ  <= crosses ? headSize : reqSize;
      tailQ  <= crosses ? tailSize : '0;
      splitQ <= crosses;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
    end
  end

  assign isSplit = splitQ;
  assign isWrite = writeQ;

  // current half on the memory port
  logic [SZ_W-1:0]   halfSize;
  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] wShift, rShift;

  always_comb begin
    halfSize = strobe.selSecond ? tailQ : headQ;
    memAddr  = strobe.selSecond ? bndQ : addrQ;
    shAmt    = strobe.selSecond ? {headQ, 3'b000} : '0;
    wShift   = wdataQ >> shAmt;
    rShift   = rspRdata << {headQ, 3'b000};
  end

  assign memSize = halfSize;

  logic [7:0] mergeB [MAX_BYTES];

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
    localparam logic [SZ_W-1:0] IDX = SZ_W'(b);

    assign memWdata[8*b +: 8] = (IDX < halfSize) ? wShift[8*b +: 8] : 8'h00;

    always_ff @(posedge clk) begin
      if (rst || strobe.capture) begin
        mergeB[b] <= 8'h00;
      end else if (strobe.load0 && (IDX < halfSize)) begin
        mergeB[b] <= rspRdata[8*b +: 8];
      end else if (strobe.load1 && (IDX >= headQ) && (IDX < sizeQ)) begin
        mergeB[b] <= rShift[8*b +: 8];
      end
    end

    assign doneRdata[8*b +: 8] = mergeB[b];
  end

endmodule

// File: rtl/lsplit_ctrl.sv
module lsplit_ctrl
  import lsplit_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           reqValid,
  input  logic           memReady,
  input  logic           rspValid,
  input  logic           isSplit,
  input  logic           isWrite,
  output logic           reqReady,
  output logic           memValid,
  output logic           doneValid,
  output lsplit_strobe_t strobe
);

  lsplit_state_t state, stateNext;
  logic [1:0]    finishCnt, finishNext;
  logic [1:0]    halvesNeeded;

  assign halvesNeeded = isSplit ? 2'd2 : 2'd1;

  always_comb begin
    stateNext  = state;
    finishNext = finishCnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext  = ST_ISSUE_A;
          finishNext = 2'd0;
        end
      end
      ST_ISSUE_A: if (memReady) stateNext = ST_WAIT_A;
      ST_WAIT_A: begin
        if (rspValid) begin
          finishNext = finishCnt + 2'd1;
          stateNext  = (finishNext == halvesNeeded) ? ST_DONE : ST_ISSUE_B;
        end
      end
      ST_ISSUE_B: if (memReady) stateNext = ST_WAIT_B;
      ST_WAIT_B: begin
        if (rspValid) begin
          finishNext = finishCnt + 2'd1;
          stateNext  = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      finishCnt <= 2'd0;
    end else begin
      state     <= stateNext;
      finishCnt <= finishNext;
    end
  end

  always_comb begin
    reqReady         = (state == ST_IDLE);
    memValid         = (state == ST_ISSUE_A) || (state == ST_ISSUE_B);
    doneValid        = (state == ST_DONE);
    strobe.capture   = (state == ST_IDLE) && reqValid;
    strobe.selSecond = (state == ST_ISSUE_B) || (state == ST_WAIT_B);
    strobe.load0     = (state == ST_WAIT_A) && rspValid && !isWrite;
    strobe.load1     = (state == ST_WAIT_B) && rspValid && !isWrite;
  end

endmodule

// File: rtl/line_split_unit.sv
module line_split_unit
  import lsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reqValid,
  output logic                           reqReady,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [$clog2(MAX_BYTES+1)-1:0] reqSize,
  input  logic                           reqWrite,
  input  logic [8*MAX_BYTES-1:0]         reqWdata,
  output logic                           memValid,
  input  logic                           memReady,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [$clog2(MAX_BYTES+1)-1:0] memSize,
  output logic                           memWrite,
  output logic [8*MAX_BYTES-1:0]         memWdata,
  input  logic                           rspValid,
  input  logic [8*MAX_BYTES-1:0]         rspRdata,
  output logic                           doneValid,
  output logic [8*MAX_BYTES-1:0]         doneRdata
);

  lsplit_strobe_t strobe;
  logic           isSplit, isWrite;

  lsplit_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .memReady  (memReady),
    .rspValid  (rspValid),
    .isSplit   (isSplit),
    .isWrite   (isWrite),
    .reqReady  (reqReady),
    .memValid  (memValid),
    .doneValid (doneValid),
    .strobe    (strobe)
  );

  lsplit_datapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .MAX_BYTES  (MAX_BYTES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .rspRdata  (rspRdata),
    .isSplit   (isSplit),
    .isWrite   (isWrite),
    .memAddr   (memAddr),
    .memSize   (memSize),
    .memWdata  (memWdata),
    .doneRdata (doneRdata)
  );

  assign memWrite = isWrite;

endmodule

// File: rtl/lsplit_chk.sv
module lsplit_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           reqReady,
  input logic                           memValid,
  input logic                           memReady,
  input logic [ADDR_W-1:0]              memAddr,
  input logic [$clog2(MAX_BYTES+1)-1:0] memSize,
  input logic                           memWrite,
  input logic [8*MAX_BYTES-1:0]         memWdata,
  input logic                           rspValid,
  input logic                           doneValid
);

  localparam int SZ_W = $clog2(MAX_BYTES + 1);
  localparam logic [ADDR_W-1:0] LMASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W:0] endOff;
  assign endOff = {1'b0, memAddr & LMASK} + (ADDR_W+1)'(memSize);

  // R1
  no_cross_chk: assert property (@(posedge clk) disable iff (rst)
    memValid |-> (endOff <= (ADDR_W+1)'(LINE_BYTES)));

  // R2
  half_size_chk: assert property (@(posedge clk) disable iff (rst)
    memValid |-> (memSize != '0) && (memSize <= SZ_W'(MAX_BYTES)));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memValid && !memReady) |=> memValid && $stable(memAddr) && $stable(memSize)
                                && $stable(memWrite) && $stable(memWdata));

  // R4
  one_out_chk: assert property (@(posedge clk) disable iff (rst)
    (memValid && memReady) |=> !memValid);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    memValid |-> !reqReady);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid && reqReady);

  // R7
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(doneValid) |-> $past(rspValid));

endmodule

bind line_split_unit lsplit_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .MAX_BYTES  (MAX_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqReady  (reqReady),
  .memValid  (memValid),
  .memReady  (memReady),
  .memAddr   (memAddr),
  .memSize   (memSize),
  .memWrite  (memWrite),
  .memWdata  (memWdata),
  .rspValid  (rspValid),
  .doneValid (doneValid)
);

// File: tb/sim_line_split_unit.sv
module sim_line_split_unit;

  localparam int ADDR_W = 32;
  localparam int LINE   = 64;
  localparam int MAXB   = 8;
  localparam int SZ_W   = $clog2(MAXB + 1);
  localparam int DW     = 8 * MAXB;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [SZ_W-1:0] reqSize = '0;
  logic            reqWrite = 1'b0;
  logic [DW-1:0]   reqWdata = '0;
  logic            memValid;
  logic            memReady = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [SZ_W-1:0] memSize;
  logic            memWrite;
  logic [DW-1:0]   memWdata;
  logic            rspValid = 1'b0;
  logic [DW-1:0]   rspRdata = '0;
  logic            doneValid;
  logic [DW-1:0]   doneRdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  line_split_unit #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr), .memSize(memSize),
    .memWrite(memWrite), .memWdata(memWdata), .rspValid(rspValid), .rspRdata(rspRdata),
    .doneValid(doneValid), .doneRdata(doneRdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [ADDR_W-1:0] a);
    return 8'(a * 7 + 32'h11) ^ a[15:8];
  endfunction

  function automatic logic [DW-1:0] memLine(input logic [ADDR_W-1:0] a);
    logic [DW-1:0] v;
    for (int j = 0; j < MAXB; j++) v[8*j +: 8] = memByte(a + ADDR_W'(j));
    return v;
  endfunction

  // bytes [off, off+n) of w moved to lane 0, rest zero
  function automatic logic [DW-1:0] slice(input logic [DW-1:0] w, input int off, input int n);
    logic [DW-1:0] v = '0;
    for (int j = 0; j < n; j++) v[8*j +: 8] = w[8*(off+j) +: 8];
    return v;
  endfunction

  task automatic checkHalf(input string tag, input logic [ADDR_W-1:0] a, input int n,
                           input bit wr, input logic [DW-1:0] wd);
    chk(memValid === 1'b1, tag, "memValid", 64'(memValid), 64'd1);
    chk(memAddr === a, tag, "memAddr", 64'(memAddr), 64'(a));
    chk(memSize === SZ_W'(n), tag, "memSize", 64'(memSize), 64'(n));
    chk(memWrite === wr, "R5", "memWrite", 64'(memWrite), 64'(wr));
    if (wr) chk(memWdata === wd, "R5", "memWdata", memWdata, wd);
  endtask

  task automatic handshakeAndRespond(input logic [ADDR_W-1:0] a, input int stall,
                                     input bit poke);
    logic [ADDR_W-1:0] hA = memAddr;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(memValid === 1'b1 && memAddr === hA, "R8", "held request",
          64'(memAddr), 64'(hA));
    end
    memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0;
    chk(memValid === 1'b0, "R4", "no second outstanding", 64'(memValid), 64'd0);
    if (poke) begin
      reqValid = 1'b1;
      reqAddr  = 32'h0000_FFF0;
      reqSize  = SZ_W'(3);
      reqWdata = 64'hDEAD_BEEF_DEAD_BEEF;
      chk(reqReady === 1'b0, "R9", "reqReady busy", 64'(reqReady), 64'd0);
      @(negedge clk);
      reqValid = 1'b0;
    end else begin
      @(negedge clk);
    end
    rspValid = 1'b1;
    rspRdata = memLine(a);
    @(negedge clk);
    rspValid = 1'b0;
    rspRdata = 64'hA5A5_A5A5_A5A5_A5A5;
  endtask

  task automatic runAccess(input string name, input logic [ADDR_W-1:0] a, input int n,
                           input bit wr, input logic [DW-1:0] wd,
                           input int stall, input bit poke);
    logic [ADDR_W-1:0] lastA = a + ADDR_W'(n) - 1;
    logic [ADDR_W-1:0] bnd = lastA & ~ADDR_W'(LINE - 1);
    bit split = bnd > a;
    int s1 = split ? int'(bnd - a) : n;
    logic [DW-1:0] expMerge = '0;
    if (!wr) for (int i = 0; i < n; i++) expMerge[8*i +: 8] = memByte(a + ADDR_W'(i));

    @(negedge clk);
    chk(reqReady === 1'b1, "R9", {name, " reqReady idle"}, 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqAddr = a; reqSize = SZ_W'(n); reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    reqWdata = ~wd;
    checkHalf(split ? "R2" : "R3", a, s1, wr, slice(wd, 0, s1));
    handshakeAndRespond(a, stall, poke);
    if (split) begin
      chk(doneValid === 1'b0, "R7", {name, " no done after first half"}, 64'(doneValid), 64'd0);
      checkHalf("R1", bnd, n - s1, wr, slice(wd, s1, n - s1));
      handshakeAndRespond(bnd, 0, 1'b0);
    end
    chk(doneValid === 1'b1, "R7", {name, " done pulse"}, 64'(doneValid), 64'd1);
    chk(doneRdata === expMerge, "R6", {name, " merged data"}, doneRdata, expMerge);
    @(negedge clk);
    chk(doneValid === 1'b0, "R7", {name, " single pulse"}, 64'(doneValid), 64'd0);
    chk(reqReady === 1'b1, "R9", {name, " idle again"}, 64'(reqReady), 64'd1);
  endtask

  task automatic strayResponse();
    @(negedge clk);
    rspValid = 1'b1;
    rspRdata = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    rspValid = 1'b0;
    chk(doneValid === 1'b0, "R10", "stray rsp no done", 64'(doneValid), 64'd0);
    chk(memValid === 1'b0 && reqReady === 1'b1, "R10", "stray rsp stays idle",
        64'({memValid, reqReady}), 64'b01);
  endtask

  task automatic resetCheck();
    chk(reqReady === 1'b1, "R11", "reqReady after reset", 64'(reqReady), 64'd1);
    chk(memValid === 1'b0, "R11", "memValid after reset", 64'(memValid), 64'd0);
    chk(doneValid === 1'b0, "R11", "doneValid after reset", 64'(doneValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    resetCheck();
    // R3 plain load inside a line
    runAccess("R3 load", 32'h0000_0100, 4, 1'b0, '0, 0, 1'b0);
    // R1 ends exactly on last byte of line: no split
    runAccess("R1 edge", 32'h0000_013C, 4, 1'b0, '0, 0, 1'b0);
    // R1 R2 R6 split load 3+5
    runAccess("R6 split load", 32'h0000_013D, 8, 1'b0, '0, 0, 1'b0);
    // R5 R8 split store 1+1 with port stall
    runAccess("R5 split store", 32'h0000_027F, 2, 1'b1, 64'h0000_0000_0000_C3B2, 3, 1'b0);
    // R9 split store 6+2 with request poked while busy
    runAccess("R9 busy poke", 32'h0000_03FA, 8, 1'b1, 64'h8877_6655_4433_2211, 1, 1'b1);
    // R10 stray response then load
    strayResponse();
    runAccess("R10 after stray", 32'h0000_047F, 1, 1'b0, '0, 0, 1'b0);
    runAccess("R5 byte store", 32'h0000_0040, 1, 1'b1, 64'h0000_0000_0000_005E, 0, 1'b0);
    runAccess("R6 split load 7+1", 32'h0000_0539, 8, 1'b0, '0, 2, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule